// File: doc/BRIEF.md
# Cross-Timestamp Snapshot Capture Unit

This block keeps three counters that run on their own: an audio wall clock, split into a cycle-in-frame count and a frame number; a 64-bit system time counter; and one 64-bit link position counter for each stream in each direction. Software picks a stream and a direction in the control register and sets the capture bit. Two clock edges later, the unit has latched the wall clock, the system time and the selected link position, all on the same edge. It then raises a done flag.

Software reads the snapshot through a small register window in 32-bit words. It acknowledges the snapshot by writing a one to the done bit. A rollover guard output is high while the latched snapshot lies so close to a frame boundary that it cannot be trusted. Software is then expected to acknowledge and retry.

Top module: `xstamp_capture`

## Requirements
- R1: After reset, `snap_done` and `near_rollover` are 0, and every register in the window reads 0.
- R2: The wall clock cycle count runs 0 to 511, one step per clock. When it wraps from 511 to 0, the frame number steps by one. The snapshot of both reads at offset 0x04, with the cycle count in bits 8:0 and the frame number in bits 31:9.
- R3: A control write (offset 0x00) with bit 5 set is accepted when no capture is pending or done. `snap_done` and control bit 31 read 0 after the accepting edge and read 1 after the next edge.
- R4: The wall clock, system time and link position in a snapshot are all taken on the same clock edge, the edge after the accepting edge.
- R5: The system counter starts at parameter `SYS_START` and counts up by one per clock. The latched 64-bit value reads low word at 0x08 and high word at 0x0C.
- R6: Control bit 4 chooses the direction (1 = playback) and bits 1:0 choose the stream index. The link position counter of that stream advances by one at each frame wrap while its run bit is high. That run bit is `stream_run[dir*NUM_STREAMS + index]`. The latched value reads low word at 0x18 and high word at 0x1C.
- R7: A capture write made while `snap_done` is set is ignored. This includes a write that sets the acknowledge bit and the capture bit together.
- R8: A control write with bit 31 set clears `snap_done` and `near_rollover` on that edge, and a new capture can then be accepted.
- R9: `near_rollover` is high with `snap_done` exactly when the latched cycle count is not both greater than 10 and less than 489.
- R10: The latched values do not change while `snap_done` stays high.
- R11: Offset 0x14 reads the latched cycle-in-frame count, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all counters and registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 5 | Byte offset of the register access |
| csr_wr | input | 1 | Write strobe for one cycle |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |
| stream_run | input | 2*NUM_STREAMS | Run enable for each link position counter |
| snap_done | output | 1 | Snapshot valid, held until acknowledged |
| near_rollover | output | 1 | Valid snapshot taken too close to a frame wrap |

## Verification
The embedded assertions check on every cycle the behaviour that a local rule can state:
- the wrap of the wall clock;
- the fixed delay from a pending capture to done;
- that the latched wall clock and system time agree;
- that the snapshot holds still under done;
- that the guard window is respected;
- that acknowledges and repeated triggers behave as required.

Only the bench scenarios can show that the values read out equal the absolute counter values expected for a chosen capture instant. The same applies to the link counter picked by each stream and direction select, the freezing of a counter when its run bit drops, and the carry of the system counter into its high word.

// File: rtl/xstamp_capture.sv
`timescale 1ns/1ps
module xstamp_capture #(
  parameter int NUM_STREAMS = 4,
  parameter int CYC_W = 9,
  parameter int GUARD_LO = 10,
  parameter int GUARD_HI = 489,
  parameter logic [63:0] SYS_START = 64'd0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [4:0] csr_addr,
  input  logic csr_wr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic [2*NUM_STREAMS-1:0] stream_run,
  output logic snap_done,
  output logic near_rollover
);
  localparam int IDX_W = $clog2(NUM_STREAMS);
  localparam int NCNT = 2 * NUM_STREAMS;
  localparam int FRAME_W = 32 - CYC_W;
  localparam logic [CYC_W-1:0] LAST_CYC = '1;
  localparam logic [CYC_W-1:0] CYC_ONE = 1;
  localparam logic [FRAME_W-1:0] FRM_ONE = 1;
  localparam logic [CYC_W-1:0] G_LO = CYC_W'(GUARD_LO);
  localparam logic [CYC_W-1:0] G_HI = CYC_W'(GUARD_HI);
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_WALL = 5'h04;
  localparam logic [4:0] A_SYSL = 5'h08;
  localparam logic [4:0] A_SYSH = 5'h0C;
  localparam logic [4:0] A_LOFF = 5'h14;
  localparam logic [4:0] A_LPL = 5'h18;
  localparam logic [4:0] A_LPH = 5'h1C;

  logic [CYC_W-1:0] cyc_q;
  logic [FRAME_W-1:0] frame_q;
  logic [63:0] sys_q;
  logic [NCNT*64-1:0] pos_flat;
  logic frame_end;
  logic busy, done_q;
  logic dir_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W:0] sel_full;
  logic [CYC_W-1:0] snap_cyc;
  logic [FRAME_W-1:0] snap_frame;
  logic [63:0] snap_sys, snap_pos;
  logic snap_bad;
  logic ctrl_wr, accept, ack;
  wire unused_wdata = ^csr_wdata;

  assign frame_end = (cyc_q == LAST_CYC);
  assign ctrl_wr = csr_wr && (csr_addr == A_CTRL);
  assign accept = ctrl_wr && csr_wdata[5] && !done_q && !busy;
  assign ack = ctrl_wr && csr_wdata[31];
  assign sel_full = {dir_q, idx_q};
  assign snap_done = done_q;
  assign near_rollover = done_q && snap_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      frame_q <= '0;
      sys_q <= SYS_START;
    end else begin
      cyc_q <= frame_end ? '0 : cyc_q + CYC_ONE;
      if (frame_end) frame_q <= frame_q + FRM_ONE;
      sys_q <= sys_q + 64'd1;
    end
  end

  for (genvar g = 0; g < NCNT; g++) begin : g_link
    logic [63:0] pos_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= '0;
      else if (frame_end && stream_run[g]) pos_q <= pos_q + 64'd1;
    end
    assign pos_flat[g*64 +: 64] = pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done_q <= 1'b0;
      dir_q <= 1'b0;
      idx_q <= '0;
    end else begin
      busy <= accept;
      if (busy) done_q <= 1'b1;
      else if (ack) done_q <= 1'b0;
      if (ctrl_wr && !busy) begin
        dir_q <= csr_wdata[4];
        idx_q <= csr_wdata[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_cyc <= '0;
      snap_frame <= '0;
      snap_sys <= '0;
      snap_pos <= '0;
      snap_bad <= 1'b0;
    end else if (busy) begin
      snap_cyc <= cyc_q;
      snap_frame <= frame_q;
      snap_sys <= sys_q;
      snap_pos <= pos_flat[{sel_full, 6'd0} +: 64];
      snap_bad <= !((cyc_q > G_LO) && (cyc_q < G_HI));
    end
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_CTRL: begin
        csr_rdata[31] = done_q;
        csr_rdata[5] = busy;
        csr_rdata[4] = dir_q;
        csr_rdata[IDX_W-1:0] = idx_q;
      end
      A_WALL: csr_rdata = {snap_frame, snap_cyc};
      A_SYSL: csr_rdata = snap_sys[31:0];
      A_SYSH: csr_rdata = snap_sys[63:32];
      A_LOFF: csr_rdata = 32'(snap_cyc);
      A_LPL: csr_rdata = snap_pos[31:0];
      A_LPH: csr_rdata = snap_pos[63:32];
      default: csr_rdata = '0;
    endcase
  end

  // R2
  wall_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cyc_q == '0) && (frame_q == $past(frame_q) + FRM_ONE));

  // R3
  done_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> done_q);

  // R3
  done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy));

  // R4
  same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ({snap_frame, snap_cyc} == 32'(snap_sys - SYS_START)));

  // R7
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ctrl_wr && csr_wdata[5]) |=> !busy);

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ack) |=> !snap_done && !near_rollover);

  // R9
  guard_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    near_rollover |-> snap_done && ((snap_cyc <= G_LO) || (snap_cyc >= G_HI)));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> ($stable(snap_sys) && $stable(snap_pos) && $stable(snap_cyc)));
endmodule

// File: tb/tb_xstamp_capture.sv
`timescale 1ns/1ps
module tb_xstamp_capture;
  localparam int NS = 4;
  localparam logic [63:0] START = 64'h0000_0002_FFFF_F800;
  localparam logic [11:0] VEC [8] = '{
    {1'b1, 2'd1, 9'd100}, {1'b0, 2'd0, 9'd10}, {1'b0, 2'd1, 9'd11}, {1'b1, 2'd2, 9'd488},
    {1'b1, 2'd3, 9'd489}, {1'b0, 2'd2, 9'd0},  {1'b1, 2'd0, 9'd511}, {1'b0, 2'd3, 9'd300}};

  logic clk = 0, rst_n = 0, csr_wr = 0;
  logic [4:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic [2*NS-1:0] run = 8'b1010_0110;
  logic snap_done, near_rollover;
  longint unsigned tcnt;
  int errors = 0, checks = 0, wd = 0;

  always #2.5 clk = ~clk;

  xstamp_capture #(.NUM_STREAMS(NS), .SYS_START(START)) dut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .stream_run(run), .snap_done(snap_done), .near_rollover(near_rollover));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= 0; else tcnt <= tcnt + 1;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", wd);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_wr = 1;
    @(posedge clk); @(negedge clk);
    csr_wr = 0; csr_wdata = 0;
  endtask

  task automatic trig(input logic dir, input logic [1:0] idx, input logic [8:0] tgt,
                      output longint unsigned c);
    while (9'((tcnt + 1) % 512) != tgt) @(negedge clk);
    c = tcnt;
    csr_addr = 5'h00; csr_wdata = 32'h20 | {27'd0, dir, 2'b00, idx}; csr_wr = 1;
    @(posedge clk); @(negedge clk);
    csr_wr = 0; csr_wdata = 0;
    chk("R3 done low after accept edge", snap_done, 0);
    @(posedge clk); @(negedge clk);
    chk("R3 done high after latch edge", snap_done, 1);
  endtask

  initial begin
    logic [31:0] d, s0, p0;
    longint unsigned c, cz;
    logic [63:0] e;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", snap_done, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done after reset", snap_done, 0);
    chk("R1 guard after reset", near_rollover, 0);
    for (int a = 0; a < 32; a += 4) begin
      rd(5'(a), d);
      chk($sformatf("R1 reg %0h after reset", a), d, 0);
    end

    for (int i = 0; i < 8; i++) begin
      logic [11:0] v;
      int b;
      logic bad;
      v = VEC[i];
      b = v[11] * NS + v[10:9];
      bad = !((v[8:0] > 10) && (v[8:0] < 489));
      trig(v[11], v[10:9], v[8:0], c);
      rd(5'h00, d);
      chk("R3 ctrl done bit", d[31], 1);
      rd(5'h04, d);
      chk("R2 R4 wall clock snapshot", d, {23'((c + 1) >> 9), v[8:0]});
      e = START + 64'(c + 1);
      rd(5'h08, d); chk("R5 system low", d, e[31:0]);
      rd(5'h0C, d); chk("R5 system high", d, e[63:32]);
      rd(5'h14, d); chk("R11 frame offset", d, 32'(v[8:0]));
      e = run[b] ? 64'((c + 1) >> 9) : 64'd0;
      rd(5'h18, d); chk($sformatf("R6 link low sel %0d", b), d, e[31:0]);
      rd(5'h1C, d); chk("R6 link high", d, e[63:32]);
      chk($sformatf("R9 guard at cycle %0d", v[8:0]), near_rollover, bad);
      wr(5'h00, 32'h8000_0000);
      chk("R8 done cleared", snap_done, 0);
      chk("R8 guard cleared", near_rollover, 0);
    end

    trig(1'b0, 2'd1, 9'd200, c);
    rd(5'h08, s0); rd(5'h18, p0);
    wr(5'h00, 32'h0000_0033);
    repeat (5) @(negedge clk);
    chk("R7 done still set", snap_done, 1);
    rd(5'h08, d); chk("R7 R10 system snapshot held", d, s0);
    rd(5'h18, d); chk("R7 R10 link snapshot held", d, p0);
    wr(5'h00, 32'h8000_0020);
    repeat (4) @(negedge clk);
    chk("R7 trigger with ack ignored", snap_done, 0);
    trig(1'b0, 2'd1, 9'd220, c);
    rd(5'h08, d);
    e = START + 64'(c + 1);
    chk("R8 rearmed capture", d, e[31:0]);
    wr(5'h00, 32'h8000_0000);

    @(negedge clk);
    cz = tcnt;
    run = '0;
    repeat (1100) @(negedge clk);
    trig(1'b0, 2'd1, 9'd50, c);
    rd(5'h18, d);
    chk("R6 link frozen when run low", d, 32'(cz >> 9));
    chk("R9 mid-frame no guard", near_rollover, 0);
    wr(5'h00, 32'h8000_0000);

    summary();
    $finish;
  end
endmodule